// File: doc/BRIEF.md
# Write-Back Snooping Cache Controller

This block controls one processor's direct-mapped, write-back cache in a small shared-memory system. Each line holds a single data word and one of three coherence states: Invalid, Shared (clean, readable) or Exclusive (dirty, readable and writable). Processor reads and writes are served from the line store when the state allows it. Otherwise the controller requests the shared bus, evicts a dirty victim if needed, and broadcasts a read-miss or write-miss transaction.

At the same time the controller watches the transactions that its peers place on the bus. A peer miss to a line held Exclusive makes this controller write the dirty word back. That word goes to memory and also to the requesting peer, which takes it in place of the stale memory word; the memory read is thereby cancelled. A peer write miss removes this cache's copy. Snoop work that changes a line always wins over a processor request that arrives in the same cycle.

Top module: `cohcache_ctl`

## Requirements
- R1: After reset, cpu_done, cpu_stall and bus_req are low and every line is Invalid, so the first access to any address needs a bus transaction.
- R2: An access to an Invalid line issues one miss (bus_cmd 1 = read miss for a read, 2 = write miss for a write) and no write-back. A read fills the line Shared with the memory word. A write fills it Exclusive with the written word.
- R3: A read whose tag matches a Shared line completes with no bus request. A read to another tag at the same index (index = address bits [IDX_W-1:0], tag = the bits above) issues only a read miss and leaves the line Shared.
- R4: Any processor write to a line held Shared issues only a write miss and leaves the line Exclusive.
- R5: Reads and writes whose tag matches an Exclusive line complete with no bus request, and a read returns the last word written.
- R6: A read or write to another tag at the index of an Exclusive line first issues a write-back (bus_cmd 3) that carries the victim's address and word, and then the miss. The line ends Shared after a read and Exclusive after a write.
- R7: A peer write miss to a line held Shared makes it Invalid, so the next local read misses and returns the peer's word.
- R8: A peer read miss to a line held Exclusive raises wb_valid for one cycle, one cycle after the miss, with the line's address and word. The line becomes Shared, and the requesting peer fills from peer_wb_data in place of mem_rdata.
- R9: A peer write miss to a line held Exclusive causes the same write-back, and the line becomes Invalid.
- R10: From the cycle after a bus-needing request is accepted until its fill completes, cpu_stall is high and bus_req is high only under it. cpu_done is a one-cycle pulse and never coincides with cpu_stall.
- R11: When a snoop changes a line in the same cycle that an idle controller would accept a processor request, the snoop is applied first and the request is not completed in that cycle.
- R12: A controller drives a non-idle bus_cmd only while bus_gnt is high, and each grant carries at most one write-back followed by one miss. Simultaneous requests from two controllers therefore end with a coherent word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_done |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_stall | output | 1 | High while a bus transaction is in progress |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant, held while bus_req is high |
| bus_cmd | output | 2 | 0 idle, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back word |
| mem_rdata | input | DATA_W | Memory word, one cycle after a miss |
| snp_cmd | input | 2 | Peer bus command (same encoding) |
| snp_addr | input | ADDR_W | Peer bus address |
| wb_valid | output | 1 | Snoop-forced write-back valid |
| wb_addr | output | ADDR_W | Snoop write-back address |
| wb_data | output | DATA_W | Snoop write-back word |
| peer_wb_valid | input | 1 | Peer is supplying the fill word |
| peer_wb_data | input | DATA_W | Word supplied by the peer |

## Verification
The bench drives two controllers on one round-robin bus and runs a reference model of both line stores and memory. It goes after conflicting-index evictions of dirty lines: a design that skipped the victim write-back would lose the word, and a later read from the other cache would return the initial memory value. It also covers peer misses to Exclusive lines. A design that did not forward the dirty word, or did not downgrade or invalidate the line, would return stale memory data or show a missing or extra bus transaction. A sweep of start offsets lines up a local write hit with a peer read miss on the same cycle. Without snoop priority the two caches end with different words for one address, which the final reads of both caches expose.

// File: rtl/cc_pkg.sv
`timescale 1ns/1ps
package cc_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    BC_IDLE  = 2'd0,
    BC_RDMIS = 2'd1,
    BC_WRMIS = 2'd2,
    BC_WBACK = 2'd3
  } bus_cmd_t;

  typedef enum logic [2:0] {
    F_IDLE = 3'd0,
    F_REQ  = 3'd1,
    F_WB   = 3'd2,
    F_MISS = 3'd3,
    F_WAIT = 3'd4
  } fsm_t;
endpackage

// File: rtl/cc_lines.sv
`timescale 1ns/1ps
module cc_lines
  import cc_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_t          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_t          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  line_st_t          fill_st,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              sst_en,
  input  logic [IDX_W-1:0]  sst_idx,
  input  line_st_t          sst_st
);
  localparam int LINES = 1 << IDX_W;

  line_st_t          st_q  [LINES];
  logic [TAG_W-1:0]  tag_m [LINES];
  logic [DATA_W-1:0] dat_m [LINES];

  // per-line state register; snoop update wins over a fill on the same line
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[g] <= LS_INV;
      end else if (sst_en && sst_idx == IDX_W'(g)) begin
        st_q[g] <= sst_st;
      end else if (fill_en && fill_idx == IDX_W'(g)) begin
        st_q[g] <= fill_st;
      end
    end
  end

  // tag and data storage: single write port, no reset
  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_m[fill_idx] <= fill_tag;
      dat_m[fill_idx] <= fill_data;
    end
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_m[a_idx];
  assign a_data = dat_m[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_m[b_idx];
  assign b_data = dat_m[b_idx];
endmodule

// File: rtl/cc_snoop.sv
`timescale 1ns/1ps
module cc_snoop
  import cc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              snp_cmd,
  input  logic [ADDR_W-1:0]       snp_addr,
  output logic [IDX_W-1:0]        s_idx,
  input  line_st_t                s_st,
  input  logic [ADDR_W-IDX_W-1:0] s_tag,
  input  logic [DATA_W-1:0]       s_data,
  output logic                    sst_en,
  output line_st_t                sst_st,
  output logic                    snoop_block,
  output logic                    wb_valid,
  output logic [ADDR_W-1:0]       wb_addr,
  output logic [DATA_W-1:0]       wb_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [TAG_W-1:0] req_tag;
  logic             is_miss;
  logic             is_wr;
  logic             hit;
  logic             need_wb;

  assign s_idx   = snp_addr[IDX_W-1:0];
  assign req_tag = snp_addr[ADDR_W-1:IDX_W];
  assign is_wr   = (snp_cmd == BC_WRMIS);
  assign is_miss = (snp_cmd == BC_RDMIS) || is_wr;
  assign hit     = is_miss && (s_st != LS_INV) && (s_tag == req_tag);
  assign need_wb = hit && (s_st == LS_EXC);

  // a peer read miss leaves a Shared copy alone; every other hit changes state
  assign sst_en      = need_wb || (hit && is_wr);
  assign sst_st      = is_wr ? LS_INV : LS_SHR;
  assign snoop_block = sst_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= need_wb;
      if (need_wb) begin
        wb_addr <= snp_addr;
        wb_data <= s_data;
      end
    end
  end
endmodule

// File: rtl/cc_fsm.sv
`timescale 1ns/1ps
module cc_fsm
  import cc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    cpu_done,
  output logic                    cpu_stall,
  output logic                    bus_req,
  input  logic                    bus_gnt,
  output logic [1:0]              bus_cmd,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  input  logic [DATA_W-1:0]       mem_rdata,
  input  logic                    peer_wb_valid,
  input  logic [DATA_W-1:0]       peer_wb_data,
  input  logic                    snoop_block,
  output logic [IDX_W-1:0]        l_idx,
  input  line_st_t                l_st,
  input  logic [ADDR_W-IDX_W-1:0] l_tag,
  input  logic [DATA_W-1:0]       l_data,
  output logic                    fill_en,
  output line_st_t                fill_st,
  output logic [ADDR_W-IDX_W-1:0] fill_tag,
  output logic [DATA_W-1:0]       fill_data,
  output logic                    fsm_idle
);
  localparam int TAG_W = ADDR_W - IDX_W;

  fsm_t             state_q;
  logic [TAG_W-1:0] req_tag;
  logic             tag_eq;
  logic             hit;
  logic             accept;
  logic             wr_hit;
  logic             rd_hit;
  logic             need_wb;
  logic [1:0]       miss_cmd;

  assign l_idx    = cpu_addr[IDX_W-1:0];
  assign req_tag  = cpu_addr[ADDR_W-1:IDX_W];
  assign tag_eq   = (l_tag == req_tag);
  assign hit      = (l_st != LS_INV) && tag_eq;
  assign rd_hit   = !cpu_we && hit;
  assign wr_hit   = cpu_we && hit && (l_st == LS_EXC);
  assign need_wb  = (l_st == LS_EXC) && !tag_eq;
  assign miss_cmd = cpu_we ? BC_WRMIS : BC_RDMIS;
  assign accept   = cpu_req && !cpu_done && !snoop_block;
  assign fsm_idle = (state_q == F_IDLE);

  // line write: a local write hit, or the fill at the end of a transaction
  assign fill_en   = (fsm_idle && accept && wr_hit) || (state_q == F_WAIT);
  assign fill_st   = (state_q == F_WAIT && !cpu_we) ? LS_SHR : LS_EXC;
  assign fill_tag  = req_tag;
  assign fill_data = cpu_we ? cpu_wdata : (peer_wb_valid ? peer_wb_data : mem_rdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= F_IDLE;
      cpu_rdata <= '0;
      cpu_done  <= 1'b0;
      cpu_stall <= 1'b0;
      bus_req   <= 1'b0;
      bus_cmd   <= BC_IDLE;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      case (state_q)
        F_IDLE: begin
          if (accept) begin
            if (rd_hit) begin
              cpu_rdata <= l_data;
              cpu_done  <= 1'b1;
            end else if (wr_hit) begin
              cpu_done <= 1'b1;
            end else begin
              state_q   <= F_REQ;
              bus_req   <= 1'b1;
              cpu_stall <= 1'b1;
            end
          end
        end
        F_REQ: begin
          // victim decision taken with the grant: snoops may have changed it
          if (bus_gnt) begin
            if (need_wb) begin
              bus_cmd   <= BC_WBACK;
              bus_addr  <= {l_tag, l_idx};
              bus_wdata <= l_data;
              state_q   <= F_WB;
            end else begin
              bus_cmd  <= miss_cmd;
              bus_addr <= cpu_addr;
              state_q  <= F_MISS;
            end
          end
        end
        F_WB: begin
          bus_cmd  <= miss_cmd;
          bus_addr <= cpu_addr;
          state_q  <= F_MISS;
        end
        F_MISS: begin
          bus_cmd <= BC_IDLE;
          state_q <= F_WAIT;
        end
        F_WAIT: begin
          cpu_rdata <= fill_data;
          cpu_done  <= 1'b1;
          cpu_stall <= 1'b0;
          bus_req   <= 1'b0;
          state_q   <= F_IDLE;
        end
        default: state_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cohcache_ctl.sv
`timescale 1ns/1ps
module cohcache_ctl
  import cc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              cpu_stall,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  input  logic              peer_wb_valid,
  input  logic [DATA_W-1:0] peer_wb_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  l_idx, s_idx;
  line_st_t          l_st, s_st, fill_st, sst_st;
  logic [TAG_W-1:0]  l_tag, s_tag, fill_tag;
  logic [DATA_W-1:0] l_data, s_data, fill_data;
  logic              fill_en, sst_en, snoop_block, fsm_idle;

  cc_lines #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk(clk), .rst(rst),
    .a_idx(l_idx), .a_st(l_st), .a_tag(l_tag), .a_data(l_data),
    .b_idx(s_idx), .b_st(s_st), .b_tag(s_tag), .b_data(s_data),
    .fill_en(fill_en), .fill_idx(l_idx), .fill_st(fill_st),
    .fill_tag(fill_tag), .fill_data(fill_data),
    .sst_en(sst_en), .sst_idx(s_idx), .sst_st(sst_st)
  );

  cc_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst(rst),
    .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .s_idx(s_idx), .s_st(s_st), .s_tag(s_tag), .s_data(s_data),
    .sst_en(sst_en), .sst_st(sst_st), .snoop_block(snoop_block),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  cc_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_stall(cpu_stall),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .mem_rdata(mem_rdata),
    .peer_wb_valid(peer_wb_valid), .peer_wb_data(peer_wb_data),
    .snoop_block(snoop_block),
    .l_idx(l_idx), .l_st(l_st), .l_tag(l_tag), .l_data(l_data),
    .fill_en(fill_en), .fill_st(fill_st), .fill_tag(fill_tag),
    .fill_data(fill_data), .fsm_idle(fsm_idle)
  );
endmodule

// File: rtl/cohcache_chk.sv
`timescale 1ns/1ps
module cohcache_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_done,
  input logic              cpu_stall,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [1:0]        bus_cmd,
  input logic [1:0]        snp_cmd,
  input logic [ADDR_W-1:0] snp_addr,
  input logic [ADDR_W-1:0] wb_addr,
  input logic              wb_valid,
  input logic              snoop_block,
  input logic              fsm_idle
);
  AST_CMD_UNDER_GNT: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd != 2'd0) |-> bus_gnt); // R12

  AST_MISS_ENDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == 2'd1 || bus_cmd == 2'd2) |=> (bus_cmd == 2'd0)); // R12

  AST_REQ_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> cpu_stall); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done); // R10

  AST_DONE_NOT_STALLED: assert property (@(posedge clk) disable iff (rst)
    cpu_stall |-> !cpu_done); // R10

  AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (rst)
    (snoop_block && fsm_idle && cpu_req && !cpu_done) |=> (!cpu_done && !cpu_stall)); // R11

  AST_WB_AFTER_MISS: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (($past(snp_cmd) == 2'd1 || $past(snp_cmd) == 2'd2)
                  && wb_addr == $past(snp_addr))); // R8

  AST_WB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wb_valid |=> !wb_valid); // R9
endmodule

bind cohcache_ctl cohcache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_done(cpu_done),
  .cpu_stall(cpu_stall), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_cmd(bus_cmd), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
  .wb_addr(wb_addr), .wb_valid(wb_valid), .snoop_block(snoop_block),
  .fsm_idle(fsm_idle)
);

// File: tb/test_cohcache_ctl.sv
`timescale 1ns/1ps
module test_cohcache_ctl;
  localparam int AW = 6;
  localparam int IW = 2;
  localparam int DW = 16;
  localparam int NL = 1 << IW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          req [2];
  logic          we  [2];
  logic [AW-1:0] addr[2];
  logic [DW-1:0] wd  [2];
  logic [DW-1:0] rdq [2];
  logic          done[2], stall[2], breq[2];
  logic [1:0]    gnt;
  logic [1:0]    bcmd[2];
  logic [AW-1:0] badr[2];
  logic [DW-1:0] bwd [2];
  logic          wbv [2];
  logic [AW-1:0] wba [2];
  logic [DW-1:0] wbd [2];
  logic [DW-1:0] mem_q;
  logic [DW-1:0] mem [1 << AW];

  cohcache_ctl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) i_cohcache_ctl (
    .clk(clk), .rst(rst), .cpu_req(req[0]), .cpu_we(we[0]), .cpu_addr(addr[0]),
    .cpu_wdata(wd[0]), .cpu_rdata(rdq[0]), .cpu_done(done[0]), .cpu_stall(stall[0]),
    .bus_req(breq[0]), .bus_gnt(gnt[0]), .bus_cmd(bcmd[0]), .bus_addr(badr[0]),
    .bus_wdata(bwd[0]), .mem_rdata(mem_q), .snp_cmd(bcmd[1]), .snp_addr(badr[1]),
    .wb_valid(wbv[0]), .wb_addr(wba[0]), .wb_data(wbd[0]),
    .peer_wb_valid(wbv[1]), .peer_wb_data(wbd[1]));

  cohcache_ctl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) i_cohcache_ctl_b (
    .clk(clk), .rst(rst), .cpu_req(req[1]), .cpu_we(we[1]), .cpu_addr(addr[1]),
    .cpu_wdata(wd[1]), .cpu_rdata(rdq[1]), .cpu_done(done[1]), .cpu_stall(stall[1]),
    .bus_req(breq[1]), .bus_gnt(gnt[1]), .bus_cmd(bcmd[1]), .bus_addr(badr[1]),
    .bus_wdata(bwd[1]), .mem_rdata(mem_q), .snp_cmd(bcmd[0]), .snp_addr(badr[0]),
    .wb_valid(wbv[1]), .wb_addr(wba[1]), .wb_data(wbd[1]),
    .peer_wb_valid(wbv[0]), .peer_wb_data(wbd[0]));

  function automatic logic [DW-1:0] init_word(input int a);
    logic [AW-1:0] s;
    s = AW'(a);
    return {2'b10, s, 2'b01, s};
  endfunction

  // round-robin arbiter, grant held while the owner requests
  logic last;
  always @(posedge clk) begin
    if (rst) begin
      gnt <= 2'b00; last <= 1'b1;
    end else if (gnt == 2'b00) begin
      if (breq[0] && (!breq[1] || last)) begin gnt <= 2'b01; last <= 1'b0; end
      else if (breq[1]) begin gnt <= 2'b10; last <= 1'b1; end
    end else if ((gnt[0] && !breq[0]) || (gnt[1] && !breq[1])) begin
      gnt <= 2'b00;
    end
  end

  // memory: registered read, write-back from bus and from snoop responses
  logic [1:0]    cmd_s;
  logic [AW-1:0] adr_s;
  logic [DW-1:0] wd_s;
  assign cmd_s = bcmd[0] | bcmd[1];
  assign adr_s = gnt[1] ? badr[1] : badr[0];
  assign wd_s  = gnt[1] ? bwd[1]  : bwd[0];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < (1 << AW); i++) mem[i] <= init_word(i);
      mem_q <= '0;
    end else begin
      mem_q <= mem[adr_s];
      if (cmd_s == 2'd3) mem[adr_s] <= wd_s;
      for (int c = 0; c < 2; c++) if (wbv[c]) mem[wba[c]] <= wbd[c];
    end
  end

  // bus monitor counters
  int n_rd[2], n_wr[2], n_wb[2], n_fw[2];
  always @(negedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin n_rd[c] = 0; n_wr[c] = 0; n_wb[c] = 0; n_fw[c] = 0; end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (bcmd[c] == 2'd1) n_rd[c]++;
        if (bcmd[c] == 2'd2) n_wr[c]++;
        if (bcmd[c] == 2'd3) n_wb[c]++;
        if (wbv[c]) n_fw[c]++;
      end
    end
  end

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc++;

  task automatic check(input string lbl, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", lbl, what, got, exp);
    end
  endtask

  // reference model: 0 invalid, 1 shared, 2 exclusive
  int            m_st [2][NL];
  logic [AW-IW-1:0] m_tag[2][NL];
  logic [DW-1:0] m_dat[2][NL];
  logic [DW-1:0] m_mem[1 << AW];

  task automatic cpu_op(input int c, input bit w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] r);
    int t;
    @(negedge clk);
    req[c] = 1'b1; we[c] = w; addr[c] = a; wd[c] = d;
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!done[c] && t < 400);
    if (!done[c]) begin
      fails++; checks++;
      $display("FAIL R10 cache %0d: no completion, got done %0d expected 1", c, done[c]);
    end
    r = rdq[c];
    req[c] = 1'b0;
  endtask

  task automatic mop(input int c, input bit w, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input string lbl_in);
    int o, ix, s_rd, s_wr, s_wb, s_fw;
    logic [AW-IW-1:0] tg;
    logic [DW-1:0] r, exp_r;
    bit hit, bus, e_wb, e_fw;
    string lbl;
    o = 1 - c; ix = int'(a[IW-1:0]); tg = a[AW-1:IW];
    hit = (m_st[c][ix] != 0) && (m_tag[c][ix] == tg);
    bus = !((!w && hit) || (w && hit && m_st[c][ix] == 2));
    e_wb = 0; e_fw = 0; exp_r = m_dat[c][ix];
    lbl = lbl_in;
    if (bus) begin
      if (m_st[c][ix] == 2 && m_tag[c][ix] != tg) begin
        e_wb = 1; m_mem[{m_tag[c][ix], a[IW-1:0]}] = m_dat[c][ix];
      end
      if (m_st[o][ix] != 0 && m_tag[o][ix] == tg) begin
        if (m_st[o][ix] == 2) begin
          e_fw = 1; m_mem[a] = m_dat[o][ix]; m_st[o][ix] = w ? 0 : 1;
        end else if (w) m_st[o][ix] = 0;
      end
      exp_r = w ? d : m_mem[a];
      m_st[c][ix] = w ? 2 : 1; m_tag[c][ix] = tg; m_dat[c][ix] = exp_r;
      if (lbl == "") lbl = e_fw ? (w ? "R9" : "R8") : (e_wb ? "R6" : "R2");
    end else begin
      if (w) m_dat[c][ix] = d;
      if (lbl == "") lbl = (m_st[c][ix] == 2) ? "R5" : "R3";
    end
    s_rd = n_rd[c]; s_wr = n_wr[c]; s_wb = n_wb[c]; s_fw = n_fw[o];
    cpu_op(c, w, a, d, r);
    if (!w) check(lbl, "read word", 32'(r), 32'(exp_r));
    check(lbl, "read-miss count", 32'(n_rd[c] - s_rd), 32'(bus && !w));
    check(lbl, "write-miss count", 32'(n_wr[c] - s_wr), 32'(bus && w));
    check(lbl, "write-back count", 32'(n_wb[c] - s_wb), 32'(e_wb));
    check(lbl, "peer write-back count", 32'(n_fw[o] - s_fw), 32'(e_fw));
  endtask

  task automatic run_all();
    logic [DW-1:0] ra, rb, v1, v2;
    for (int c = 0; c < 2; c++) begin
      req[c] = 0; we[c] = 0; addr[c] = '0; wd[c] = '0;
      for (int i = 0; i < NL; i++) begin m_st[c][i] = 0; m_tag[c][i] = '0; m_dat[c][i] = '0; end
    end
    for (int i = 0; i < (1 << AW); i++) m_mem[i] = init_word(i);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      check("R1", "cpu_done after reset", 32'(done[c]), 0);
      check("R1", "cpu_stall after reset", 32'(stall[c]), 0);
      check("R1", "bus_req after reset", 32'(breq[c]), 0);
    end
    // directed sequence, index 1 conflicts across tags
    mop(0, 0, 6'h05, 16'h0, "R1");
    mop(0, 0, 6'h05, 16'h0, "R3");
    mop(0, 1, 6'h05, 16'h1111, "R4");
    mop(0, 1, 6'h05, 16'h2222, "R5");
    mop(0, 0, 6'h05, 16'h0, "R5");
    mop(1, 0, 6'h05, 16'h0, "R8");
    mop(1, 1, 6'h05, 16'h3333, "R4");
    mop(0, 0, 6'h05, 16'h0, "R7");
    mop(0, 0, 6'h09, 16'h0, "R3");
    mop(0, 1, 6'h0D, 16'h4444, "R2");
    mop(0, 0, 6'h11, 16'h0, "R6");
    mop(1, 0, 6'h0D, 16'h0, "R6");
    mop(0, 1, 6'h11, 16'h5555, "R4");
    mop(0, 1, 6'h15, 16'h6666, "R6");
    mop(1, 1, 6'h15, 16'h7777, "R9");
    mop(0, 0, 6'h15, 16'h0, "R9");
    mop(1, 1, 6'h02, 16'h8888, "R2");
    // random mix on a few tags per index
    void'($urandom(32'd20240611));
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] a;
      a = {AW-IW'($urandom_range(0, 2)), IW'($urandom_range(0, NL - 1))};
      mop(int'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), a, DW'($urandom), "");
    end
    // R11: local write hit racing a peer read miss on the same line
    for (int d = 0; d < 14; d++) begin
      v1 = DW'(16'hA000 + d); v2 = DW'(16'hB000 + d);
      cpu_op(0, 1, 6'h23, v1, ra);
      fork
        begin cpu_op(1, 0, 6'h23, '0, rb); end
        begin repeat (d) @(negedge clk); cpu_op(0, 1, 6'h23, v2, ra); end
      join
      cpu_op(0, 0, 6'h23, '0, ra);
      cpu_op(1, 0, 6'h23, '0, rb);
      check("R11", "local read after race", 32'(ra), 32'(v2));
      check("R11", "peer read after race", 32'(rb), 32'(v2));
    end
    // R12: simultaneous write misses to one address are serialized
    fork
      begin cpu_op(0, 1, 6'h1A, 16'hC0C0, ra); end
      begin cpu_op(1, 1, 6'h1A, 16'hD0D0, rb); end
    join
    cpu_op(0, 0, 6'h1A, '0, ra);
    cpu_op(1, 0, 6'h1A, '0, rb);
    check("R12", "both caches agree", 32'(ra), 32'(rb));
    check("R12", "word is one of the writes", 32'(ra == 16'hC0C0 || ra == 16'hD0D0), 1);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin req[c] = 0; we[c] = 0; addr[c] = '0; wd[c] = '0; end
    fork
      run_all();
      begin
        wait (cyc >= 150000);
        fails++; checks++;
        $display("FAIL R10 watchdog: got cycle %0d expected below 150000", cyc);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule